// File: doc/BRIEF.md
# Predictive Synchronous-Rectifier Gate Timer

This block drives the two switches on the secondary side of a forward converter: the rectifier switch, which conducts while the digitized transformer clock is high, and the freewheeling switch, which conducts while it is low. The block does not wait for a clock edge to end a conduction interval. It counts the length of each high and low phase on an internal tick, which is a clock enable taken from the system clock. In the next cycle it releases each gate a fixed number of ticks before the edge it predicts, so the two switches never overlap.

The lead time for the rectifier gate is fixed. The lead time for the freewheeling gate comes from a two-bit selection input. Both lead times are given in nanoseconds and converted to ticks by rounding up, so a gate is always released early and never late. The clock input is synchronized and passes through a pulse-width filter. An inhibit input can cut the freewheeling conduction short, but not below a minimum on-time. A duty-cycle guard with hysteresis parks both gates when the high phase becomes too narrow. A supply-good input blanks both gates and discards every measurement.

Top module: `sr_gate_ctrl`

## Requirements
- R1: `gate_rect` and `gate_fw` are never high in the same cycle. Each gate rises only inside its own phase of the filtered clock. The filtered clock follows `ck_in` with a constant delay.
- R2: Consider a high phase of H ticks whose predecessor high phase measured P ticks. In that phase `gate_rect` is high from the phase start for min(H, max(0, P − A1)) ticks, where A1 = ceil(ANT1_NS / TICK_NS).
- R3: Consider a low phase of L ticks whose predecessor low phase measured Q ticks. In that phase `gate_fw` is high from the phase start for min(L, max(0, Q − A2)) ticks. A2 = ceil(ns / TICK_NS), where `ant2_sel` 0 selects 75 ns, 1 selects 150 ns, and both 2 and 3 select 225 ns.
- R4: When an edge comes before the predicted release, the active gate drops with that edge. The next prediction for that phase uses the shortened length.
- R5: After reset or after a supply-good return, both gates stay low until one complete high phase and one complete low phase, each bounded by filtered edges, have been measured.
- R6: A level change of `ck_in` lasting fewer than MIN_PULSE ticks is ignored, and the surrounding phase is counted as one phase. A change lasting MIN_PULSE ticks is taken as a real phase.
- R7: With `duty_guard_en` high, the duty cycle is evaluated at every rising edge as 100·Hprev / (Hprev + L), using the latest complete high phase and the low phase just ended. If the result is below DUTY_OFF_PCT (13), both gates stay low from that edge.
- R8: Once parked, the block resumes only at a rising edge where the same duty figure is at least DUTY_ON_PCT (14). A figure in [13, 14) keeps it parked.
- R9: With `duty_guard_en` low, narrow duty cycles never park the gates.
- R10: While `inhibit` is high, `gate_fw` is high for at most MIN_ON ticks from the low-phase start, and still for at least min(MIN_ON, R3 count) ticks.
- R11: Three cycles after `supply_ok` goes low, both gates are low and stay low for as long as it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ck_in | input | 1 | Digitized transformer clock, asynchronous |
| supply_ok | input | 1 | Supply-good level, asynchronous; low blanks and clears |
| inhibit | input | 1 | Freewheeling cut-off request, asynchronous |
| ant2_sel | input | 2 | Freewheeling lead-time selection (static) |
| duty_guard_en | input | 1 | Enables the low-duty park function (static) |
| gate_rect | output | 1 | Rectifier switch gate enable |
| gate_fw | output | 1 | Freewheeling switch gate enable |

## Verification
The embedded properties watch four things on every cycle: that the gates never overlap, that the gates are blank under a held supply fault, that the phase counter saturates instead of wrapping, and that the glitch run counter stays bounded. They also check that the parked state changes only at a rising edge, which enforces the hysteresis timing. The exact on-time of each gate, the rounding of the lead times, early-edge shortening, glitch merging, the park and resume thresholds, and the inhibit minimum cannot be seen one cycle at a time. The bench scenarios show them instead, by comparing the total gate-on ticks of each scenario with a phase-by-phase model.

// File: rtl/sr_gate_pkg.sv
package sr_gate_pkg;

  // Convert a time in ns to ticks, rounding up so a gate always releases early.
  function automatic int unsigned ns_to_ticks(input int unsigned ns, input int unsigned tick_ns);
    return (ns + tick_ns - 1) / tick_ns;
  endfunction

  // Freewheeling lead time in ns for each selection code.
  function automatic int unsigned fw_lead_ns(input logic [1:0] code);
    case (code)
      2'd0:    return 75;
      2'd1:    return 150;
      default: return 225;
    endcase
  endfunction

  // Saturating difference, floor at zero.
  function automatic int unsigned sub_floor(input int unsigned a, input int unsigned b);
    return (a > b) ? a - b : 0;
  endfunction

  // True when hi/(hi+lo) is below pct percent.
  function automatic logic duty_below(input int unsigned hi, input int unsigned lo,
                                      input int unsigned pct);
    return (hi * 100) < (pct * (hi + lo));
  endfunction

endpackage

// File: rtl/sr_tick_gen.sv
module sr_tick_gen #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_every
      assign tick = 1'b1;
    end else begin : g_div
      localparam int unsigned DW = $clog2(DIV);
      localparam logic [DW-1:0] LAST = DW'(DIV - 1);
      logic [DW-1:0] div_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             div_q <= '0;
        else if (div_q == LAST) div_q <= '0;
        else                    div_q <= div_q + 1'b1;
      end
      assign tick = (div_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/sr_edge_filter.sv
module sr_edge_filter #(
  parameter int unsigned MIN_PULSE = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic ck_raw,
  input  logic ok_raw,
  input  logic inh_raw,
  output logic ck_f,
  output logic flip,
  output logic ok_s,
  output logic inh_s
);
  localparam int unsigned FW = $clog2(MIN_PULSE + 1);
  localparam logic [FW-1:0] LAST = FW'(MIN_PULSE - 1);

  logic [2:0] sy1, sy2;
  logic       ck_s2, differ;
  logic [FW-1:0] run_cnt;

  // Two-flop synchronizers for the three asynchronous levels.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1 <= '0;
      sy2 <= '0;
    end else begin
      sy1 <= {inh_raw, ok_raw, ck_raw};
      sy2 <= sy1;
    end
  end
  assign ck_s2 = sy2[0];
  assign ok_s  = sy2[1];
  assign inh_s = sy2[2];

  assign differ = ck_s2 ^ ck_f;
  assign flip   = tick & differ & (run_cnt == LAST);

  // The filtered level changes only after MIN_PULSE ticks of disagreement.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
      ck_f    <= 1'b0;
    end else begin
      if (!differ)   run_cnt <= '0;
      else if (tick) run_cnt <= flip ? '0 : run_cnt + 1'b1;
      ck_f <= ck_f ^ flip;
    end
  end

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt <= LAST);
  p_filter_agree_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ck_f) |-> $past(ck_s2 != ck_f));
endmodule

// File: rtl/sr_phase_timer.sv
module sr_phase_timer
  import sr_gate_pkg::*;
#(
  parameter int unsigned CW       = 12,
  parameter int unsigned OFF_PCT  = 13,
  parameter int unsigned ON_PCT   = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          flip,
  input  logic          ck_f,
  input  logic          ok_s,
  input  logic          guard_en,
  output logic [CW-1:0] ph_cnt,
  output logic [CW-1:0] t_hi,
  output logic [CW-1:0] t_lo,
  output logic          valid,
  output logic          shut
);
  localparam logic [CW-1:0] CMAX = '1;

  logic          armed, seen_hi, seen_lo;
  logic [CW-1:0] len;
  logic          rise_ev, fall_ev, too_low, high_enough;

  assign len         = (ph_cnt == CMAX) ? CMAX : ph_cnt + 1'b1;
  assign rise_ev     = flip & ~ck_f;
  assign fall_ev     = flip & ck_f;
  assign too_low     = duty_below(32'(t_hi), 32'(len), OFF_PCT);
  assign high_enough = !duty_below(32'(t_hi), 32'(len), ON_PCT);
  assign valid       = seen_hi & seen_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_cnt  <= '0;
      t_hi    <= '0;
      t_lo    <= '0;
      armed   <= 1'b0;
      seen_hi <= 1'b0;
      seen_lo <= 1'b0;
      shut    <= 1'b0;
    end else begin
      if (flip)                           ph_cnt <= '0;
      else if (tick && ph_cnt != CMAX)    ph_cnt <= ph_cnt + 1'b1;

      if (!ok_s) begin
        armed   <= 1'b0;
        seen_hi <= 1'b0;
        seen_lo <= 1'b0;
        shut    <= 1'b0;
      end else if (flip) begin
        armed <= 1'b1;
        if (armed && fall_ev) begin
          t_hi    <= len;
          seen_hi <= 1'b1;
        end
        if (armed && rise_ev) begin
          t_lo    <= len;
          seen_lo <= 1'b1;
          if (seen_hi) shut <= guard_en & (shut ? !high_enough : too_low);
        end
      end
    end
  end

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_cnt == CMAX && !flip) |=> ph_cnt == CMAX);
  p_shut_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (shut && ok_s && !rise_ev) |=> shut);
  p_shut_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shut) |-> $past(rise_ev));
endmodule

// File: rtl/sr_gate_ctrl.sv
module sr_gate_ctrl
  import sr_gate_pkg::*;
#(
  parameter int unsigned TICK_DIV     = 4,
  parameter int unsigned TICK_NS      = 67,
  parameter int unsigned ANT1_NS      = 20,
  parameter int unsigned MIN_PULSE    = 2,
  parameter int unsigned MIN_ON       = 4,
  parameter int unsigned CW           = 12,
  parameter int unsigned DUTY_OFF_PCT = 13,
  parameter int unsigned DUTY_ON_PCT  = 14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ck_in,
  input  logic       supply_ok,
  input  logic       inhibit,
  input  logic [1:0] ant2_sel,
  input  logic       duty_guard_en,
  output logic       gate_rect,
  output logic       gate_fw
);
  localparam logic [CW-1:0] A1     = CW'(ns_to_ticks(ANT1_NS, TICK_NS));
  localparam logic [CW-1:0] MON_T  = CW'(MIN_ON);

  logic          tick, ck_f, flip, ok_s, inh_s, valid, shut, run;
  logic [CW-1:0] ph_cnt, t_hi, t_lo, a2, rect_lim, fw_lim;

  sr_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  sr_edge_filter #(.MIN_PULSE(MIN_PULSE)) u_filt (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .ck_raw(ck_in), .ok_raw(supply_ok), .inh_raw(inhibit),
    .ck_f(ck_f), .flip(flip), .ok_s(ok_s), .inh_s(inh_s)
  );

  sr_phase_timer #(.CW(CW), .OFF_PCT(DUTY_OFF_PCT), .ON_PCT(DUTY_ON_PCT)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .flip(flip), .ck_f(ck_f),
    .ok_s(ok_s), .guard_en(duty_guard_en),
    .ph_cnt(ph_cnt), .t_hi(t_hi), .t_lo(t_lo), .valid(valid), .shut(shut)
  );

  always_comb begin
    a2       = CW'(ns_to_ticks(fw_lead_ns(ant2_sel), TICK_NS));
    rect_lim = CW'(sub_floor(32'(t_hi), 32'(A1)));
    fw_lim   = CW'(sub_floor(32'(t_lo), 32'(a2)));
  end

  assign run       = ok_s & valid & ~shut;
  assign gate_rect = run & ck_f & (ph_cnt < rect_lim);
  assign gate_fw   = run & ~ck_f & (ph_cnt < fw_lim) & (~inh_s | (ph_cnt < MON_T));

  p_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_rect && gate_fw));
  p_uvlo_blank_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!supply_ok && $past(!supply_ok) && $past(!supply_ok, 2)) |-> (!gate_rect && !gate_fw));
endmodule

// File: tb/sr_gate_ctrl_tb.sv
module sr_gate_ctrl_tb;
  localparam int TNS = 67;
  localparam int A1NS = 20;
  localparam int MW = 3;
  localparam int MON = 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, ck_in = 1'b0, supply_ok = 1'b0, inhibit = 1'b0, guard = 1'b1;
  logic [1:0] sel = 2'd0;
  logic gate_rect, gate_fw;

  sr_gate_ctrl #(.TICK_DIV(1), .TICK_NS(TNS), .ANT1_NS(A1NS), .MIN_PULSE(MW),
                 .MIN_ON(MON), .CW(12)) u_dut (
    .clk(clk), .rst_n(rst_n), .ck_in(ck_in), .supply_ok(supply_ok), .inhibit(inhibit),
    .ant2_sel(sel), .duty_guard_en(guard), .gate_rect(gate_rect), .gate_fw(gate_fw)
  );

  int total = 0, fails = 0;
  bit done = 0, cnt_en = 0;
  int c1, c2, cb;
  int np;
  int hs[0:15], ls[0:15], gls[0:15];

  function automatic int lead_ticks(input int ns);
    return ns / TNS + (((ns % TNS) != 0) ? 1 : 0);
  endfunction
  function automatic int fw_ns_of(input int code);
    if (code == 0) return 75;
    if (code == 1) return 150;
    return 225;
  endfunction
  function automatic int pos(input int v);
    return (v < 0) ? 0 : v;
  endfunction
  function automatic int mn(input int a, input int b);
    return (a < b) ? a : b;
  endfunction
  function automatic bit pct_under(input int hi, input int lo, input int p);
    return ((hi * 100) / (hi + lo)) < p;
  endfunction

  task automatic chk(input bit good, input string req, input int act, input int exp);
    total++;
    if (!good) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input logic v);
    @(negedge clk);
    if (cnt_en) begin
      c1 += int'(gate_rect);
      c2 += int'(gate_fw);
      if (gate_rect && gate_fw) cb++;
    end
    ck_in = v;
  endtask

  task automatic setp(input int i, input int h, input int l, input int g);
    hs[i] = h; ls[i] = l; gls[i] = g;
  endtask

  // Phase-by-phase model of the expected gate-on totals.
  task automatic model(output int e1, output int e2);
    int th, tl, a1, a2, lim, cap;
    bit sh, sl, park;
    th = 0; tl = 0; sh = 0; sl = 0; park = 0; e1 = 0; e2 = 0;
    a1 = lead_ticks(A1NS);
    a2 = lead_ticks(fw_ns_of(int'(sel)));
    for (int i = 0; i < np; i++) begin
      if (sh && sl && !park) e1 += mn(hs[i], pos(th - a1));
      th = hs[i]; sh = 1;
      lim = pos(tl - a2);
      cap = inhibit ? mn(lim, MON) : lim;
      if (sh && sl && !park) e2 += (i == np - 1) ? cap : mn(ls[i], cap);
      if (i < np - 1) begin
        tl = ls[i]; sl = 1;
        if (!guard) park = 0;
        else if (!park) park = pct_under(th, ls[i], 13);
        else park = pct_under(th, ls[i], 14);
      end
    end
  endtask

  task automatic run_seg(input string r1, input string r2, input logic [1:0] s,
                         input logic inh, input logic g);
    int e1, e2, a;
    cnt_en = 0;
    supply_ok = 1'b0;
    repeat (6) step(1'b0);
    sel = s; inhibit = inh; guard = g;
    supply_ok = 1'b1;
    repeat (10) step(1'b0);
    c1 = 0; c2 = 0; cb = 0; cnt_en = 1;
    for (int i = 0; i < np; i++) begin
      if (gls[i] > 0) begin
        a = hs[i] / 2;
        repeat (a) step(1'b1);
        repeat (gls[i]) step(1'b0);
        repeat (hs[i] - a - gls[i]) step(1'b1);
      end else begin
        repeat (hs[i]) step(1'b1);
      end
      repeat (ls[i]) step(1'b0);
    end
    repeat (90) step(1'b0);
    cnt_en = 0;
    model(e1, e2);
    chk(c1 == e1, r1, c1, e1);
    chk(c2 == e2, r2, c2, e2);
    chk(cb == 0, "R1 overlap", cb, 0);
  endtask

  task automatic summary;
    $display("  %0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      summary();
      $finish;
    end
  end

  initial begin
    int bad;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    chk(!gate_rect && !gate_fw, "R5 reset state", int'(gate_rect) + int'(gate_fw), 0);
    rst_n = 1'b1;
    supply_ok = 1'b1;
    repeat (20) step(1'b0);
    chk(!gate_rect && !gate_fw, "R5 idle after reset", int'(gate_rect) + int'(gate_fw), 0);

    // R2/R3: base pattern under each lead selection, code 3 equals 225 ns.
    np = 4;
    setp(0, 20, 22, 0); setp(1, 25, 22, 0); setp(2, 30, 30, 0); setp(3, 18, 25, 0);
    run_seg("R2 rect on-time", "R3 fw lead code0", 2'd0, 1'b0, 1'b1);
    run_seg("R2 rect on-time", "R3 fw lead code1", 2'd1, 1'b0, 1'b1);
    run_seg("R2 rect on-time", "R3 fw lead code2", 2'd2, 1'b0, 1'b1);
    run_seg("R2 rect on-time", "R3 fw lead code3", 2'd3, 1'b0, 1'b1);

    // R5: first period after supply return gives no output.
    np = 2;
    setp(0, 30, 30, 0); setp(1, 30, 30, 0);
    run_seg("R5 first period blank", "R5 first period blank fw", 2'd0, 1'b0, 1'b1);

    // R4: early edge cuts the rectifier gate and shortens the next prediction.
    np = 5;
    setp(0, 30, 20, 0); setp(1, 30, 20, 0); setp(2, 10, 20, 0); setp(3, 30, 8, 0);
    setp(4, 30, 20, 0);
    run_seg("R4 early edge rect", "R4 early edge fw", 2'd0, 1'b0, 1'b1);

    // R6: rejected glitch merges, accepted pulse splits.
    np = 3;
    setp(0, 30, 20, 0); setp(1, 30, 20, MW - 1); setp(2, 30, 20, 0);
    run_seg("R6 glitch rejected", "R6 glitch rejected fw", 2'd0, 1'b0, 1'b1);
    np = 4;
    setp(0, 15, MW, 0); setp(1, 15, 20, 0); setp(2, 30, 20, 0); setp(3, 30, 20, 0);
    run_seg("R6 pulse accepted", "R6 pulse accepted fw", 2'd0, 1'b0, 1'b1);

    // R7/R8: park at 9 percent, stay parked at 13.04 percent, resume at 50.
    np = 6;
    setp(0, 20, 20, 0); setp(1, 4, 40, 0); setp(2, 6, 40, 0); setp(3, 6, 40, 0);
    setp(4, 20, 20, 0); setp(5, 20, 20, 0);
    run_seg("R7 R8 park and hysteresis", "R7 R8 park and hysteresis fw", 2'd0, 1'b0, 1'b1);
    np = 4;
    setp(0, 20, 20, 0); setp(1, 4, 40, 0); setp(2, 6, 40, 0); setp(3, 6, 40, 0);
    run_seg("R8 stays parked in band", "R8 stays parked in band fw", 2'd0, 1'b0, 1'b1);

    // R9: same narrow pattern with the guard off.
    np = 6;
    setp(0, 20, 20, 0); setp(1, 4, 40, 0); setp(2, 6, 40, 0); setp(3, 6, 40, 0);
    setp(4, 20, 20, 0); setp(5, 20, 20, 0);
    run_seg("R9 guard off rect", "R9 guard off fw", 2'd0, 1'b0, 1'b0);

    // R10: inhibit limits the freewheeling gate to its minimum on-time.
    np = 4;
    setp(0, 20, 40, 0); setp(1, 20, 40, 0); setp(2, 20, 40, 0); setp(3, 20, 40, 0);
    run_seg("R10 inhibit rect", "R10 inhibit min on", 2'd2, 1'b1, 1'b1);
    np = 4;
    setp(0, 20, 6, 0); setp(1, 20, 6, 0); setp(2, 20, 6, 0); setp(3, 20, 6, 0);
    run_seg("R10 inhibit short rect", "R10 inhibit under lead", 2'd0, 1'b1, 1'b1);

    // R11: supply drop in the middle of conduction blanks both gates.
    inhibit = 1'b0; guard = 1'b1; sel = 2'd0;
    repeat (3) begin
      repeat (20) step(1'b1);
      repeat (20) step(1'b0);
    end
    repeat (5) step(1'b1);
    supply_ok = 1'b0;
    repeat (3) step(1'b1);
    bad = 0;
    for (int k = 0; k < 60; k++) begin
      step(((k / 10) % 2) == 0);
      if (gate_rect || gate_fw) bad++;
    end
    chk(bad == 0, "R11 blank under supply fault", bad, 0);

    // Random periods and configurations.
    for (int s = 0; s < 25; s++) begin
      np = 3 + int'($urandom_range(5, 0));
      for (int i = 0; i < np; i++)
        setp(i, int'($urandom_range(60, 6)), int'($urandom_range(60, 6)), 0);
      run_seg("R2 random", "R3 random", 2'($urandom_range(3, 0)),
              1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)));
    end

    done = 1;
    summary();
    $finish;
  end
endmodule